// File: doc/BRIEF.md
# Packet Transmit Frame Assembler

The assembler turns one outgoing packet into a serial bit stream. A frame is launched by a start pulse. The block then emits, in this order: a fixed preamble byte, the destination address, an optional sender address, the payload bytes the host supplies, and a 16-bit CRC. The CRC covers the address and payload fields.

Stored register values reach the block as plain input ports. The destination address comes from one of two places, chosen by a mode bit. It is either taken from the destination register value, or it is the first bytes the host writes, ahead of the payload. The sender address is always taken from its own register value and has the same length as the destination address.

Host bytes enter on a byte-wide valid/ready port. Serial bits leave one per accepted transfer on a second valid/ready port. A one-cycle done pulse marks the end of the frame.

Top module: `txf_assembler`

## Requirements
- R1: After reset, `bit_valid`, `in_ready` and `done` are low. No bit is emitted until `tx_start` is pulsed, even when `in_valid` is held high.
- R2: A frame is sent in this byte order: preamble 0xAA, destination address, sender address (if enabled), payload, CRC high byte, CRC low byte. Each byte is sent most significant bit first.
- R3: With `dst_inband` = 0, the destination address is the low L bytes of `dst_addr`. The first byte sent is bits [8L-1:8L-8] and the last is bits [7:0].
- R4: With `dst_inband` = 1, the first L host bytes of the frame form the destination address. They are sent in the order written, so the first byte written is the most significant. `in_last` is ignored on these bytes.
- R5: With `snd_en` = 1, L sender bytes taken from `snd_addr` follow the destination address, using the same ordering as R3. With `snd_en` = 0, no sender field is sent.
- R6: The address length L is `addr_len` clamped to the range 1 to 5. A value of 0 gives 1, and a value of 6 or 7 gives 5.
- R7: The CRC is CRC-16 with polynomial 0x1021 and seed 0xFFFF, computed bit by bit, MSB first, with no final inversion. It covers the destination, sender and payload bits only.
- R8: The payload ends with the host byte marked by `in_last`. The number of host bytes in a frame, counting in-band address bytes and payload bytes together, is capped at 37 (296 bits). The 37th host byte ends the payload whether or not it is marked.
- R9: A bit moves only in a cycle where `bit_valid` and `bit_ready` are both high. While `bit_valid` is high and `bit_ready` is low, `bit_out` and `bit_valid` hold their values.
- R10: `done` is high for exactly one cycle per frame, after the last CRC bit has been transferred. After it, the next `tx_start` is accepted.
- R11: While a frame is in progress, `tx_start` pulses are ignored, and so are changes to `dst_inband`, `snd_en` and `addr_len`.
- R12: A host byte moves when `in_valid` and `in_ready` are both high. `in_ready` is high only while the block is collecting an in-band address byte or a payload byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tx_start | input | 1 | Pulse that launches a frame when idle |
| dst_inband | input | 1 | 1: destination address comes from host bytes; 0: from `dst_addr` |
| snd_en | input | 1 | Insert the sender address field |
| addr_len | input | 3 | Address length in bytes, clamped to 1..5 |
| dst_addr | input | 40 | Stored destination address, low bytes used |
| snd_addr | input | 40 | Stored sender address, low bytes used |
| in_valid | input | 1 | Host byte valid |
| in_data | input | 8 | Host byte |
| in_last | input | 1 | Marks the last payload byte |
| in_ready | output | 1 | Block accepts a host byte |
| bit_out | output | 1 | Serial frame bit |
| bit_valid | output | 1 | `bit_out` holds a frame bit |
| bit_ready | input | 1 | Downstream takes the bit |
| done | output | 1 | One-cycle end-of-frame pulse |

## Verification
The bench builds the block with its default parameters: five address bytes at most and a 37-byte host cap. This makes every address length reachable, including the clamp codes 0 and 7 through the 3-bit length field. It also lets a frame that is never marked as ending run into the byte cap within a few hundred cycles. Three `bit_ready` patterns (always high, one gap in three, two highs in five) stall the serializer at different points inside bytes. The bench rebuilds each expected frame, including a byte-wise CRC, from the requirements.

// File: rtl/txf_pkg.sv
package txf_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_PRE,
    PH_DST,
    PH_SND,
    PH_PAY,
    PH_CRCH,
    PH_CRCL,
    PH_END
  } phase_e;

  // One MSB-first CRC step for a single bit.
  function automatic logic [15:0] crc16_bit(input logic [15:0] c,
                                            input logic        b,
                                            input logic [15:0] poly);
    logic fb;
    fb = c[15] ^ b;
    crc16_bit = {c[14:0], 1'b0} ^ (fb ? poly : 16'h0000);
  endfunction

endpackage

// File: rtl/txf_shifter.sv
module txf_shifter (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load,
  input  logic [7:0] load_byte,
  input  logic       load_crc,
  input  logic       bit_ready,
  output logic       empty,
  output logic       bit_out,
  output logic       bit_valid,
  output logic       crc_feed
);
  localparam int BYTE_W = 8;
  localparam int CNT_W  = $clog2(BYTE_W + 1);

  logic [BYTE_W-1:0] sh;
  logic [CNT_W-1:0]  cnt;
  logic              feed_q;
  logic              fire;

  assign empty     = (cnt == '0);
  assign bit_valid = !empty;
  assign bit_out   = sh[BYTE_W-1];
  assign fire      = bit_valid && bit_ready;
  assign crc_feed  = fire && feed_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh     <= '0;
      cnt    <= '0;
      feed_q <= 1'b0;
    end else if (load) begin
      sh     <= load_byte;
      cnt    <= CNT_W'(BYTE_W);
      feed_q <= load_crc;
    end else if (fire) begin
      sh  <= {sh[BYTE_W-2:0], 1'b0};
      cnt <= cnt - CNT_W'(1);
    end
  end

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_valid && !bit_ready) |=> (bit_valid && $stable(bit_out))); // R9
  AST_LOAD_WHEN_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> empty); // R9

endmodule

// File: rtl/txf_crc.sv
module txf_crc #(
  parameter logic [15:0] POLY = 16'h1021,
  parameter logic [15:0] SEED = 16'hFFFF
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        init,
  input  logic        feed,
  input  logic        bit_in,
  output logic [15:0] crc
);
  import txf_pkg::*;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    crc <= SEED;
    else if (init) crc <= SEED;
    else if (feed) crc <= crc16_bit(crc, bit_in, POLY);
  end

  AST_CRC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!init && !feed) |=> $stable(crc)); // R7

endmodule

// File: rtl/txf_seq.sv
module txf_seq #(
  parameter int         MAX_ADDR_BYTES = 5,
  parameter int         MAX_HOST_BYTES = 37,
  parameter logic [7:0] PREAMBLE       = 8'hAA,
  localparam int        LEN_W          = $clog2(MAX_ADDR_BYTES + 1),
  localparam int        ADDR_W         = 8 * MAX_ADDR_BYTES,
  localparam int        HCNT_W         = $clog2(MAX_HOST_BYTES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_start,
  input  logic              dst_inband,
  input  logic              snd_en,
  input  logic [LEN_W-1:0]  addr_len,
  input  logic [ADDR_W-1:0] dst_addr,
  input  logic [ADDR_W-1:0] snd_addr,
  input  logic              in_valid,
  input  logic [7:0]        in_data,
  input  logic              in_last,
  input  logic              empty,
  input  logic [15:0]       crc,
  output logic              in_ready,
  output logic              load,
  output logic [7:0]        load_byte,
  output logic              load_crc,
  output logic              crc_init,
  output logic              done
);
  import txf_pkg::*;

  phase_e             phase, nxt;
  logic               inb_q, snd_q;
  logic [LEN_W-1:0]   len_q, len_eff, sel;
  logic [LEN_W-1:0]   idx;
  logic [HCNT_W-1:0]  hcnt;
  logic               take, last_addr, cap_hit, host_phase;

  function automatic logic [LEN_W-1:0] clamp_len(input logic [LEN_W-1:0] raw);
    if (raw == '0)                              clamp_len = LEN_W'(1);
    else if (raw > LEN_W'(MAX_ADDR_BYTES))      clamp_len = LEN_W'(MAX_ADDR_BYTES);
    else                                        clamp_len = raw;
  endfunction

  function automatic logic [7:0] pick(input logic [ADDR_W-1:0] v,
                                      input logic [LEN_W-1:0]  s);
    pick = v[int'(s)*8 +: 8];
  endfunction

  assign len_eff    = clamp_len(addr_len);
  assign sel        = len_q - idx - LEN_W'(1);
  assign last_addr  = (idx == len_q - LEN_W'(1));
  assign cap_hit    = (hcnt == HCNT_W'(MAX_HOST_BYTES - 1));
  assign host_phase = (phase == PH_PAY) || (phase == PH_DST && inb_q);
  assign in_ready   = empty && host_phase;
  assign take       = in_ready && in_valid;
  assign crc_init   = (phase == PH_IDLE) && tx_start;
  assign done       = (phase == PH_END) && empty;

  always_comb begin
    nxt       = phase;
    load      = 1'b0;
    load_byte = '0;
    load_crc  = 1'b0;
    case (phase)
      PH_IDLE: if (tx_start) nxt = PH_PRE;
      PH_PRE: if (empty) begin
        load      = 1'b1;
        load_byte = PREAMBLE;
        nxt       = PH_DST;
      end
      PH_DST: if (empty && (!inb_q || in_valid)) begin
        load      = 1'b1;
        load_crc  = 1'b1;
        load_byte = inb_q ? in_data : pick(dst_addr, sel);
        if (last_addr) nxt = snd_q ? PH_SND : PH_PAY;
      end
      PH_SND: if (empty) begin
        load      = 1'b1;
        load_crc  = 1'b1;
        load_byte = pick(snd_addr, sel);
        if (last_addr) nxt = PH_PAY;
      end
      PH_PAY: if (take) begin
        load      = 1'b1;
        load_crc  = 1'b1;
        load_byte = in_data;
        if (in_last || cap_hit) nxt = PH_CRCH;
      end
      PH_CRCH: if (empty) begin
        load      = 1'b1;
        load_byte = crc[15:8];
        nxt       = PH_CRCL;
      end
      PH_CRCL: if (empty) begin
        load      = 1'b1;
        load_byte = crc[7:0];
        nxt       = PH_END;
      end
      PH_END: if (empty) nxt = PH_IDLE;
      default: nxt = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_IDLE;
      inb_q <= 1'b0;
      snd_q <= 1'b0;
      len_q <= LEN_W'(1);
      idx   <= '0;
      hcnt  <= '0;
    end else begin
      phase <= nxt;
      if (crc_init) begin
        inb_q <= dst_inband;
        snd_q <= snd_en;
        len_q <= len_eff;
        idx   <= '0;
        hcnt  <= '0;
      end else begin
        if (take) hcnt <= hcnt + HCNT_W'(1);
        if (load && (phase == PH_DST || phase == PH_SND))
          idx <= last_addr ? '0 : idx + LEN_W'(1);
      end
    end
  end

  AST_TAKE_FILLS: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> !in_ready); // R12
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && !load)); // R10
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_start && phase != PH_IDLE) |=> ($stable(len_q) && $stable(inb_q) && $stable(snd_q))); // R11
  AST_HOST_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    hcnt <= HCNT_W'(MAX_HOST_BYTES)); // R8
  AST_LEN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (phase != PH_IDLE) |-> (len_q >= LEN_W'(1) && len_q <= LEN_W'(MAX_ADDR_BYTES))); // R6

endmodule

// File: rtl/txf_assembler.sv
module txf_assembler #(
  parameter int          MAX_ADDR_BYTES = 5,
  parameter int          MAX_HOST_BYTES = 37,
  parameter logic [7:0]  PREAMBLE       = 8'hAA,
  parameter logic [15:0] CRC_POLY       = 16'h1021,
  parameter logic [15:0] CRC_SEED       = 16'hFFFF,
  localparam int         LEN_W          = $clog2(MAX_ADDR_BYTES + 1),
  localparam int         ADDR_W         = 8 * MAX_ADDR_BYTES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_start,
  input  logic              dst_inband,
  input  logic              snd_en,
  input  logic [LEN_W-1:0]  addr_len,
  input  logic [ADDR_W-1:0] dst_addr,
  input  logic [ADDR_W-1:0] snd_addr,
  input  logic              in_valid,
  input  logic [7:0]        in_data,
  input  logic              in_last,
  output logic              in_ready,
  output logic              bit_out,
  output logic              bit_valid,
  input  logic              bit_ready,
  output logic              done
);
  logic        sh_empty;
  logic        sh_load;
  logic [7:0]  sh_byte;
  logic        sh_crc;
  logic        crc_start;
  logic        crc_feed;
  logic [15:0] crc_val;

  txf_seq #(
    .MAX_ADDR_BYTES(MAX_ADDR_BYTES),
    .MAX_HOST_BYTES(MAX_HOST_BYTES),
    .PREAMBLE      (PREAMBLE)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .tx_start  (tx_start),
    .dst_inband(dst_inband),
    .snd_en    (snd_en),
    .addr_len  (addr_len),
    .dst_addr  (dst_addr),
    .snd_addr  (snd_addr),
    .in_valid  (in_valid),
    .in_data   (in_data),
    .in_last   (in_last),
    .empty     (sh_empty),
    .crc       (crc_val),
    .in_ready  (in_ready),
    .load      (sh_load),
    .load_byte (sh_byte),
    .load_crc  (sh_crc),
    .crc_init  (crc_start),
    .done      (done)
  );

  txf_shifter u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (sh_load),
    .load_byte(sh_byte),
    .load_crc (sh_crc),
    .bit_ready(bit_ready),
    .empty    (sh_empty),
    .bit_out  (bit_out),
    .bit_valid(bit_valid),
    .crc_feed (crc_feed)
  );

  txf_crc #(
    .POLY(CRC_POLY),
    .SEED(CRC_SEED)
  ) u_crc (
    .clk   (clk),
    .rst_n (rst_n),
    .init  (crc_start),
    .feed  (crc_feed),
    .bit_in(bit_out),
    .crc   (crc_val)
  );

  AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !bit_valid); // R10

endmodule

// File: tb/txf_assembler_bench.sv
module txf_assembler_bench;
  localparam int CLK_PERIOD = 10;
  localparam int MAXA = 5;
  localparam int MAXH = 37;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tx_start = 1'b0, dst_inband = 1'b0, snd_en = 1'b0;
  logic [2:0]  addr_len = 3'd1;
  logic [39:0] dst_addr = '0, snd_addr = '0;
  logic        in_valid = 1'b0, in_last = 1'b0, bit_ready = 1'b0;
  logic [7:0]  in_data = '0;
  logic        in_ready, bit_out, bit_valid, done;

  int n_cmp = 0;
  int n_bad = 0;
  int wd = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  txf_assembler u_txf_assembler (
    .clk(clk), .rst_n(rst_n), .tx_start(tx_start), .dst_inband(dst_inband),
    .snd_en(snd_en), .addr_len(addr_len), .dst_addr(dst_addr), .snd_addr(snd_addr),
    .in_valid(in_valid), .in_data(in_data), .in_last(in_last), .in_ready(in_ready),
    .bit_out(bit_out), .bit_valid(bit_valid), .bit_ready(bit_ready), .done(done)
  );

  typedef struct packed {
    logic        inb;
    logic        snd;
    logic [2:0]  len;
    logic [5:0]  npay;
    logic [7:0]  seed;
    logic [39:0] dst;
    logic [39:0] src;
    logic [1:0]  rmode;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{1'b0, 1'b0, 3'd1, 6'd1,  8'h10, 40'h00_0000_00C3, 40'h0,              2'd0}, // R3
    '{1'b0, 1'b1, 3'd3, 6'd4,  8'h22, 40'h00_00A1_B2C3, 40'h00_0055_6677,   2'd1}, // R5
    '{1'b1, 1'b0, 3'd2, 6'd3,  8'h37, 40'h0,            40'h0,              2'd2}, // R4
    '{1'b1, 1'b1, 3'd5, 6'd6,  8'h4C, 40'h0,            40'h11_2233_4455,   2'd1}, // R4 R5
    '{1'b0, 1'b1, 3'd5, 6'd10, 8'h5E, 40'hF0_E1D2_C3B4, 40'h0A_1B2C_3D4E,   2'd2}, // R7
    '{1'b0, 1'b0, 3'd4, 6'd2,  8'h6B, 40'h00_DEAD_BEEF, 40'h0,              2'd0}  // R2
  };

  logic exp_bits [0:1023];
  int   exp_n;
  logic got_bits [0:1023];

  function automatic logic [7:0] hb(input logic [7:0] seed, input int i);
    hb = seed + 8'(i * 29) + 8'd1;
  endfunction

  function automatic logic rdy_pat(input int mode, input int c);
    case (mode)
      0:       rdy_pat = 1'b1;
      1:       rdy_pat = (c % 3) != 2;
      default: rdy_pat = (c % 5) < 2;
    endcase
  endfunction

  function automatic int clampl(input logic [2:0] raw);
    if (raw == 3'd0)        clampl = 1;
    else if (int'(raw) > MAXA) clampl = MAXA;
    else                    clampl = int'(raw);
  endfunction

  task automatic push_byte(input logic [7:0] b);
    for (int k = 7; k >= 0; k--) begin
      exp_bits[exp_n] = b[k];
      exp_n++;
    end
  endtask

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic run_frame(input logic inb, input logic snd, input logic [2:0] len_raw,
                           input int npay, input logic [7:0] seed,
                           input logic [39:0] dst, input logic [39:0] src,
                           input int rmode, input bit use_last, input bit last_early,
                           input bit disturb, input string tag);
    int L, off, pay, nsup, hptr, got_n, dones, done_bits, cyc, done_cyc, hold_bad, first_bad;
    logic [15:0] c;
    logic [7:0]  b;
    bit took, prev_stall, prev_bit;
    L   = clampl(len_raw);
    off = inb ? L : 0;
    pay = use_last ? npay : MAXH - off;
    if (off + pay > MAXH) pay = MAXH - off;
    // expected frame from the requirements
    exp_n = 0;
    c = 16'hFFFF;
    push_byte(8'hAA);
    for (int k = 0; k < 2 * L + pay; k++) begin
      if (k < L)          b = inb ? hb(seed, k) : dst[8*(L-1-k) +: 8];
      else if (k < 2 * L) begin
        if (!snd) continue;
        b = src[8*(2*L-1-k) +: 8];
      end else            b = hb(seed, off + (k - 2 * L));
      push_byte(b);
      c = c ^ {b, 8'h00};
      for (int j = 0; j < 8; j++) c = c[15] ? ((c << 1) ^ 16'h1021) : (c << 1);
    end
    push_byte(c[15:8]);
    push_byte(c[7:0]);
    nsup = off + (use_last ? npay : 45);
    // drive
    @(negedge clk);
    dst_inband = inb; snd_en = snd; addr_len = len_raw; dst_addr = dst; snd_addr = src;
    tx_start = 1'b1;
    @(negedge clk);
    tx_start = 1'b0;
    hptr = 0; got_n = 0; dones = 0; done_bits = -1; cyc = 0; done_cyc = 0; hold_bad = 0;
    took = 1'b0; prev_stall = 1'b0; prev_bit = 1'b0;
    while (cyc < 6000) begin
      if (took) hptr++;
      in_valid = (hptr < nsup);
      in_data  = hb(seed, hptr);
      in_last  = (use_last && hptr == off + npay - 1) || (last_early && hptr < off);
      took     = in_valid && in_ready;
      if (prev_stall && !(bit_valid && bit_out == prev_bit)) hold_bad++;
      bit_ready = rdy_pat(rmode, cyc);
      if (bit_valid && bit_ready && got_n < 1024) begin
        got_bits[got_n] = bit_out;
        got_n++;
      end
      prev_stall = bit_valid && !bit_ready;
      prev_bit   = bit_out;
      if (done) begin
        dones++;
        done_bits = got_n;
        if (dones == 1) done_cyc = cyc;
      end
      if (disturb && cyc == 40) begin
        tx_start = 1'b1; addr_len = 3'd2; dst_inband = ~inb; snd_en = ~snd;
      end else tx_start = 1'b0;
      if (dones > 0 && cyc > done_cyc + 6) break;
      @(negedge clk);
      cyc++;
    end
    in_valid = 1'b0; in_last = 1'b0; bit_ready = 1'b0;
    first_bad = -1;
    for (int k = 0; k < exp_n; k++)
      if (first_bad < 0 && (k >= got_n || got_bits[k] !== exp_bits[k])) first_bad = k;
    check(got_n == exp_n, tag, "frame bit count", got_n, exp_n);
    if (first_bad >= 0)
      check(1'b0, tag, $sformatf("frame bit %0d", first_bad),
            (first_bad < got_n) ? int'(got_bits[first_bad]) : -1, int'(exp_bits[first_bad]));
    else
      check(1'b1, tag, "frame bits", 0, 0);
    check(dones == 1, "R10", "done pulses", dones, 1);
    check(done_bits == exp_n, "R10", "bits before done", done_bits, exp_n);
    check(hold_bad == 0, "R9", "stall hold violations", hold_bad, 0);
  endtask

  always @(posedge clk) begin
    wd++;
    if (wd > 150000) begin
      n_cmp++; n_bad++;
      $display("FAIL R10 watchdog: actual timeout expected frame end");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(!bit_valid, "R1", "bit_valid after reset", int'(bit_valid), 0);
    check(!in_ready,  "R1", "in_ready after reset",  int'(in_ready), 0);
    check(!done,      "R1", "done after reset",      int'(done), 0);
    // R1 / R12: host byte offered with no start is not taken, nothing emitted
    in_valid = 1'b1; in_data = 8'h5A; dst_inband = 1'b1; bit_ready = 1'b1;
    begin
      int seen;
      seen = 0;
      for (int k = 0; k < 10; k++) begin
        @(negedge clk);
        if (bit_valid || in_ready || done) seen++;
      end
      check(seen == 0, "R12", "activity without start", seen, 0);
    end
    in_valid = 1'b0; bit_ready = 1'b0;

    // vector table
    for (int i = 0; i < 6; i++)
      run_frame(VECS[i].inb, VECS[i].snd, VECS[i].len, int'(VECS[i].npay), VECS[i].seed,
                VECS[i].dst, VECS[i].src, int'(VECS[i].rmode), 1'b1, 1'b0, 1'b0,
                "R2/R3/R4/R5/R7");

    // R6 length clamp, low and high
    run_frame(1'b0, 1'b1, 3'd0, 3, 8'h81, 40'h00_0000_0099, 40'h00_0000_0077, 1, 1'b1, 1'b0, 1'b0, "R6");
    run_frame(1'b0, 1'b1, 3'd7, 2, 8'h92, 40'h12_3456_789A, 40'hA9_8765_4321, 0, 1'b1, 1'b0, 1'b0, "R6");
    // R8 host byte cap, with and without in-band address
    run_frame(1'b1, 1'b0, 3'd2, 0, 8'hA3, 40'h0, 40'h0, 0, 1'b0, 1'b0, 1'b0, "R8");
    run_frame(1'b0, 1'b1, 3'd1, 0, 8'hB4, 40'h00_0000_00E7, 40'h00_0000_007E, 1, 1'b0, 1'b0, 1'b0, "R8");
    // R11 start pulse and config changes mid-frame
    run_frame(1'b0, 1'b0, 3'd3, 10, 8'hC5, 40'h00_0010_2030, 40'h0, 1, 1'b1, 1'b0, 1'b1, "R11");
    // R4 last flag on in-band address bytes ignored
    run_frame(1'b1, 1'b1, 3'd3, 2, 8'hD6, 40'h0, 40'h00_00CA_FE01, 2, 1'b1, 1'b1, 1'b0, "R4");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule